// File: doc/BRIEF.md
# Synchronous Clock Stop Gating

This block sits after the frequency synthesizer and turns groups of already generated clocks on and off without damaging any pulse. A processor-side group is driven from one source clock and a bus-side group from a second source clock. The bus-side group also has one free-running output. Three active-low requests stop these clocks: a processor stop, a bus stop and a global power-down. Each output also has an enable bit: 1 lets that output run and 0 holds it low. A stopped or disabled output is driven low and is never left floating.

Each request passes through a two-flop synchronizer clocked by the source clock of the group it acts on. The synchronized result and the output's enable bit are combined and applied through a latch-based clock-gate cell. The gate's enable can therefore change only while the source clock is low. Every output pulse is either the full high phase of its source clock or is absent, and stopping and restarting both fall on cycle boundaries. Counted in rising edges of the group's source clock, the latency is fixed at two edges after the edge that samples the request. An asynchronous request therefore lands two to three source cycles after it changes.

Top module: `clk_stop_gate`

## Requirements
- R1: When the processor stop request is sampled low at a processor rising edge n, every processor output has no high phase from cycle n+2 onward. The high phases of cycles n and n+1 are delivered complete.
- R2: When the processor stop request (with power-down inactive) is sampled high at edge n, the enabled processor outputs deliver full high phases from cycle n+2 onward.
- R3: The bus stop request is sampled on the bus source clock with the same two-edge latency. While it is active, all seven stoppable bus outputs stay low.
- R4: The free-running bus output is unaffected by the bus stop request. It is stopped only by power-down, reset or its own enable bit.
- R5: Power-down, sampled low in each domain, holds every output low (processor, stoppable bus and free-running bus) with the same two-edge latency and on the same cycle boundaries. Releasing it restarts the outputs the same way.
- R6: An enable bit of 0 holds its output low and a bit of 1 lets it run. The value present during the low phase that ends at edge n governs the high phase that starts at edge n.
- R7: A gate enable changes only while its source clock is low. Every output high phase equals a whole source high phase, and outputs are low whenever their source clock is low.
- R8: During reset the synchronizers hold the stopped state, so all outputs are low. They stay low for the first two rising edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Processor-group source clock |
| pci_clk_i | input | 1 | Bus-group source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_stop_ni | input | 1 | Processor stop request, active low, asynchronous |
| pci_stop_ni | input | 1 | Bus stop request, active low, asynchronous |
| pwr_dn_ni | input | 1 | Global power-down request, active low, asynchronous |
| cpu_en_i | input | N_CPU | Per-output enable for processor outputs (1 = run) |
| pci_free_en_i | input | 1 | Enable for the free-running bus output (1 = run) |
| pci_en_i | input | N_PCI | Per-output enable for stoppable bus outputs (1 = run) |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_free_o | output | 1 | Free-running bus clock, gated only by power-down and its enable |
| pci_clk_o | output | N_PCI | Gated stoppable bus clocks |

## Verification
The latency properties assume that each request holds one level across the rising edge that samples it. The stimulus satisfies this by changing every request and enable bit 1.5 ns after a processor rising edge. The bus clock runs at one third of the processor rate with aligned rising edges, so no input ever moves on an edge of either clock. The glitch property assumes that the two source clocks are clean and that reset is applied for several cycles. The bench holds reset across four processor cycles and releases it between edges. A late stretch drives the requests and enables with pseudo-random levels, changing them at the same safe point of each processor cycle.

// File: rtl/ckg_pkg.sv
`timescale 1ns/1ps
package ckg_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned N_CPU_DEF   = 4;
  localparam int unsigned N_PCI_DEF   = 7;

  typedef struct packed {
    logic pwr_n;
    logic stop_n;
  } req_t;
endpackage

// File: rtl/ckg_sync.sv
`timescale 1ns/1ps
module ckg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  // reset value 0 = stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= '0;
    else         stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ckg_cell.sv
`timescale 1ns/1ps
module ckg_cell (
  input  logic clk_i,
  input  logic en_i,
  output logic en_q_o,
  output logic gclk_o
);
  logic en_q;

  // transparent only while clk is low
  always_latch begin
    if (!clk_i) en_q <= en_i;
  end

  assign en_q_o = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/ckg_group.sv
`timescale 1ns/1ps
module ckg_group #(
  parameter int unsigned N = 1
) (
  input  logic         clk_i,
  input  logic         run_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] en_q_o,
  output logic [N-1:0] gclk_o
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    ckg_cell u_cell (
      .clk_i  (clk_i),
      .en_i   (run_i & en_i[g]),
      .en_q_o (en_q_o[g]),
      .gclk_o (gclk_o[g])
    );
  end
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
  import ckg_pkg::*;
#(
  parameter int unsigned N_CPU       = N_CPU_DEF,
  parameter int unsigned N_PCI       = N_PCI_DEF,
  parameter int unsigned SYNC_STAGES = ckg_pkg::SYNC_STAGES
) (
  input  logic             cpu_clk_i,
  input  logic             pci_clk_i,
  input  logic             rst_ni,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  input  logic             pwr_dn_ni,
  input  logic [N_CPU-1:0] cpu_en_i,
  input  logic             pci_free_en_i,
  input  logic [N_PCI-1:0] pci_en_i,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic             pci_free_o,
  output logic [N_PCI-1:0] pci_clk_o
);
  req_t cpu_req_s, pci_req_s;
  logic cpu_run, pci_run, pci_free_run;
  logic [N_CPU-1:0] cpu_en_q;
  logic [N_PCI-1:0] pci_en_q;
  logic [0:0]       pci_free_en_q;
  logic [0:0]       pci_free_gclk;

  ckg_sync #(.W($bits(req_t)), .STAGES(SYNC_STAGES)) u_cpu_sync (
    .clk_i  (cpu_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pwr_dn_ni, cpu_stop_ni}),
    .q_o    (cpu_req_s)
  );

  ckg_sync #(.W($bits(req_t)), .STAGES(SYNC_STAGES)) u_pci_sync (
    .clk_i  (pci_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pwr_dn_ni, pci_stop_ni}),
    .q_o    (pci_req_s)
  );

  assign cpu_run      = cpu_req_s.pwr_n & cpu_req_s.stop_n;
  assign pci_run      = pci_req_s.pwr_n & pci_req_s.stop_n;
  assign pci_free_run = pci_req_s.pwr_n;

  ckg_group #(.N(N_CPU)) u_cpu_grp (
    .clk_i  (cpu_clk_i),
    .run_i  (cpu_run),
    .en_i   (cpu_en_i),
    .en_q_o (cpu_en_q),
    .gclk_o (cpu_clk_o)
  );

  ckg_group #(.N(N_PCI)) u_pci_grp (
    .clk_i  (pci_clk_i),
    .run_i  (pci_run),
    .en_i   (pci_en_i),
    .en_q_o (pci_en_q),
    .gclk_o (pci_clk_o)
  );

  // exempt from the bus stop request
  ckg_group #(.N(1)) u_free_grp (
    .clk_i  (pci_clk_i),
    .run_i  (pci_free_run),
    .en_i   (pci_free_en_i),
    .en_q_o (pci_free_en_q),
    .gclk_o (pci_free_gclk)
  );

  assign pci_free_o = pci_free_gclk[0];
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
  parameter int unsigned N_CPU = 4,
  parameter int unsigned N_PCI = 7
) (
  input logic             cpu_clk_i,
  input logic             pci_clk_i,
  input logic             rst_ni,
  input logic             cpu_stop_ni,
  input logic             pci_stop_ni,
  input logic             pwr_dn_ni,
  input logic             cpu_run,
  input logic             pci_run,
  input logic             pci_free_run,
  input logic [N_CPU-1:0] cpu_en_q,
  input logic [N_PCI-1:0] pci_en_q,
  input logic [0:0]       pci_free_en_q
);
  // R1
  cpu_stop_lat_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    !$past(cpu_stop_ni, 2) |-> !cpu_run);

  // R2
  cpu_restart_lat_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    ($past(cpu_stop_ni, 2) && $past(pwr_dn_ni, 2) && $past(rst_ni, 2)) |-> cpu_run);

  // R3
  pci_stop_lat_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    !$past(pci_stop_ni, 2) |-> !pci_run);

  // R4
  pci_free_runs_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    ($past(pwr_dn_ni, 2) && $past(rst_ni, 2)) |-> pci_free_run);

  // R5
  cpu_pwr_dn_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    !$past(pwr_dn_ni, 2) |-> !cpu_run);

  // R5
  pci_pwr_dn_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    !$past(pwr_dn_ni, 2) |-> (!pci_run && !pci_free_run));

  // R7
  always @(cpu_en_q) begin
    if (rst_ni === 1'b1) cpu_gate_low_chk: assert (cpu_clk_i == 1'b0);
  end

  // R7
  always @(pci_en_q or pci_free_en_q) begin
    if (rst_ni === 1'b1) pci_gate_low_chk: assert (pci_clk_i == 1'b0);
  end
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
  .cpu_clk_i     (cpu_clk_i),
  .pci_clk_i     (pci_clk_i),
  .rst_ni        (rst_ni),
  .cpu_stop_ni   (cpu_stop_ni),
  .pci_stop_ni   (pci_stop_ni),
  .pwr_dn_ni     (pwr_dn_ni),
  .cpu_run       (cpu_run),
  .pci_run       (pci_run),
  .pci_free_run  (pci_free_run),
  .cpu_en_q      (cpu_en_q),
  .pci_en_q      (pci_en_q),
  .pci_free_en_q (pci_free_en_q)
);

// File: tb/tb_clk_stop_gate.sv
`timescale 1ns/1ps
module tb_clk_stop_gate;
  localparam int NC = 4;
  localparam int NP = 7;

  logic cpu_clk = 1'b0, pci_clk = 1'b0, rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_n = 1'b1;
  logic [NC-1:0] cpu_en = '1;
  logic [NP-1:0] pci_en = '1;
  logic pcif_en = 1'b1;
  logic [NC-1:0] cpu_o;
  logic [NP-1:0] pci_o;
  logic pcif_o;

  int n_cmp = 0, n_bad = 0;

  clk_stop_gate dut (
    .cpu_clk_i     (cpu_clk),
    .pci_clk_i     (pci_clk),
    .rst_ni        (rst_n),
    .cpu_stop_ni   (cpu_stop_n),
    .pci_stop_ni   (pci_stop_n),
    .pwr_dn_ni     (pwr_n),
    .cpu_en_i      (cpu_en),
    .pci_free_en_i (pcif_en),
    .pci_en_i      (pci_en),
    .cpu_clk_o     (cpu_o),
    .pci_free_o    (pcif_o),
    .pci_clk_o     (pci_o)
  );

  // 200 MHz processor clock, bus clock at one third with aligned rising edges
  initial forever #2.5 cpu_clk = ~cpu_clk;
  initial forever #7.5 pci_clk = ~pci_clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // cause codes: 8 reset, 5 power-down, 1 cpu stop, 3 bus stop, 4 free running, 2 running
  function automatic string tag_of(input int c);
    case (c)
      8: return "R8";
      5: return "R5";
      1: return "R1";
      3: return "R3";
      4: return "R4";
      default: return "R2";
    endcase
  endfunction

  // processor-domain reference: request sampled at edge n gates high phase n+2
  initial begin
    int cq[$];
    cq.push_back(8); cq.push_back(8);
    forever begin
      int c;
      logic [NC-1:0] exp;
      string tag;
      @(posedge cpu_clk);
      #1;
      c = !rst_n ? 8 : !pwr_n ? 5 : !cpu_stop_n ? 1 : 2;
      cq.push_back(c);
      c = cq[$-2];
      if (cq.size() > 3) void'(cq.pop_front());
      exp = (c == 2) ? cpu_en : '0;
      tag = (c == 2 && cpu_en != '1) ? "R6" : tag_of(c);
      chk(tag, 32'(cpu_o), 32'(exp));
      #1.2;
      chk("R7", 32'(cpu_o), 32'(exp));      // still high near end of high phase
      @(negedge cpu_clk);
      #1;
      chk("R7", 32'(cpu_o), 32'd0);         // low phase always low
    end
  end

  // bus-domain reference
  initial begin
    int pq[$];
    int fq[$];
    pq.push_back(8); pq.push_back(8);
    fq.push_back(8); fq.push_back(8);
    forever begin
      int c, f;
      logic [NP-1:0] exp;
      logic expf;
      string tag;
      @(posedge pci_clk);
      #1;
      c = !rst_n ? 8 : !pwr_n ? 5 : !pci_stop_n ? 3 : 2;
      f = !rst_n ? 8 : !pwr_n ? 5 : 4;
      pq.push_back(c);
      fq.push_back(f);
      c = pq[$-2];
      f = fq[$-2];
      if (pq.size() > 3) void'(pq.pop_front());
      if (fq.size() > 3) void'(fq.pop_front());
      exp  = (c == 2) ? pci_en : '0;
      expf = (f == 4) ? pcif_en : 1'b0;
      tag = (c == 2 && pci_en != '1) ? "R6" : tag_of(c);
      chk(tag, 32'(pci_o), 32'(exp));
      chk((f == 4 && !pcif_en) ? "R6" : tag_of(f), 32'(pcif_o), 32'(expf));
      #5;
      chk("R7", 32'(pci_o), 32'(exp));
      chk("R7", 32'(pcif_o), 32'(expf));
      @(negedge pci_clk);
      #1;
      chk("R7", {24'd0, pci_o, pcif_o}, 32'd0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge cpu_clk);
    #1.5;
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;                              // R8 first cycles stay low
    step(10);
    cpu_stop_n = 1'b0; step(8);                // R1
    cpu_stop_n = 1'b1; step(8);                // R2
    pci_stop_n = 1'b0; step(20);               // R3, R4
    pci_stop_n = 1'b1; step(12);
    cpu_en = 4'b0101; pci_en = 7'h2a; step(6); // R6
    cpu_en = 4'b1010; pcif_en = 1'b0; step(9);
    cpu_en = '1; pci_en = '1; pcif_en = 1'b1; step(6);
    pwr_n = 1'b0; step(20);                    // R5
    pwr_n = 1'b1; step(15);
    cpu_stop_n = 1'b0; step(1);                // one-cycle stop pulse
    cpu_stop_n = 1'b1; step(6);
    pci_stop_n = 1'b0; cpu_en = 4'b0011; step(12);
    pwr_n = 1'b0; step(3);
    pwr_n = 1'b1; pci_stop_n = 1'b1; cpu_en = '1; step(12);
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0) cpu_stop_n = ~cpu_stop_n;
      if ($urandom_range(0, 9) == 0) pci_stop_n = ~pci_stop_n;
      if ($urandom_range(0, 19) == 0) pwr_n = ~pwr_n;
      if ($urandom_range(0, 5) == 0) cpu_en = NC'($urandom);
      if ($urandom_range(0, 5) == 0) pci_en = NP'($urandom);
      if ($urandom_range(0, 11) == 0) pcif_en = ~pcif_en;
      step(1);
    end
    step(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #250000;
    n_bad++;
    $display("watchdog expired at %0t", $time);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule